// File: doc/BRIEF.md
# Masked Cascadable Content-Addressable Memory

This block is a small associative store: a parameterised number of wide entries, each with a validity bit, searched all at once against a comparand word. It is loaded and read through a narrow data bus, so one entry travels as several bus-sized segments. A control register picks one of two mask registers, or none. The chosen mask does two jobs. In a search it marks don't-care bits. In a data write it marks bits that must keep their old value.

A search registers three results: a local match flag, a multiple-match flag and the address of the winning entry. The winner is the lowest-addressed valid entry that matches. Several devices can be chained through active-low match-in/match-out and full-in/full-out signals. An upstream match blocks any update aimed at the local winning entry, and a device whose match flag is disabled passes the chain signal straight through. A next-free output gives the lowest empty entry. An address register with optional auto-step after the last segment makes sequential loading easy.

Operations are issued one per clock on a 4-bit opcode together with a segment number and a 16-bit data word.

Top module: `masked_cam`

## Requirements
- R1: Opcode 1 writes the control register with the data word. Bit 15 always reads back as 0 on `ctrl_out`. Writing a word with bit 15 set acts exactly like the synchronous reset.
- R2: While `rst` is high, or after a control write with bit 15 set, the following state holds: every validity bit is cleared, the comparand, both masks, the address register and the control register are zero, `ma_n` and `mm_n` are 1, `match_addr` is 0 and `rd_data` is 0.
- R3: The compare opcode (8) registers its result on the same clock edge. After that edge, `ma_n` is 0 when at least one valid entry equals the comparand on every bit that is not masked. `mm_n` is 0 when two or more valid entries match.
- R4: After a compare, `match_addr` holds the lowest address among the matching valid entries. It holds 0 when nothing matches.
- R5: Control bits 5:4 choose the mask: 01 selects mask 1, 10 selects mask 2, and 00 or 11 selects no mask. A mask bit of 1 makes that bit a don't-care in a compare. The mask registers are written per segment with opcodes 3 and 4, and the comparand with opcode 2.
- R6: Opcode 6 writes segment `seg` of the entry at the address register. Segment 0 holds bits 15:0. Bits set in the selected mask keep their previous value.
- R7: Opcode 5 loads the address register from the data word. After a data write to the last segment, control bits 3:2 step the register: 01 adds one, 10 subtracts one, and any other value leaves it unchanged.
- R8: Opcode 7 sets the validity bit to `din[0]`. When `din[1]` is 0, the target is the entry at the address register. Invalid entries never match.
- R9: When `din[1]` is 1, opcode 7 targets the entry named by the last match. It is ignored when the last compare found nothing, when control bits 14:13 equal 01 (match flag disabled), or when `mi_n` is 0.
- R10: With the match flag enabled, `mf_n` is 0 when `mi_n` is 0 or the local `ma_n` is 0. With control bits 14:13 equal to 01, `mf_n` equals `mi_n`.
- R11: `next_free` is the lowest invalid address, and 0 when every entry is valid. With control bits 12:11 not equal to 01, `ff_n` is 0 exactly when every entry is valid and `fi_n` is 0. With 12:11 equal to 01, `ff_n` equals `fi_n`.
- R12: Opcode 9 loads `rd_data` with segment `seg` of the entry at the address register. The value appears after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code, 0 = idle |
| seg | input | SW | Segment number within an entry |
| din | input | BUS | Data word for the operation |
| mi_n | input | 1 | Match from the upstream device, active low |
| fi_n | input | 1 | Full from the upstream device, active low |
| ma_n | output | 1 | Local match, active low |
| mm_n | output | 1 | Local multiple match, active low |
| mf_n | output | 1 | Match to the downstream device, active low |
| ff_n | output | 1 | Full to the downstream device, active low |
| match_addr | output | AW | Highest-priority matching address |
| next_free | output | AW | Lowest empty address |
| rd_data | output | BUS | Segment returned by a read |
| ctrl_out | output | 16 | Control register readback |

## Verification
The bench builds the block with 8 entries of 64 bits on a 16-bit bus. With only 8 entries, every entry can be loaded and validated in a few operations, so the all-valid state is easy to reach. That state is where `next_free` wraps to 0 and where `ff_n` starts to follow `fi_n`. The 64-bit width keeps four segments per entry. That makes the per-segment mask protection and the auto-step after the final segment visible. It also lets duplicate entries produce a multiple match.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_CTRL    = 4'd1,
    OP_CMP     = 4'd2,
    OP_MSK1    = 4'd3,
    OP_MSK2    = 4'd4,
    OP_ADDR    = 4'd5,
    OP_DATA    = 4'd6,
    OP_VALID   = 4'd7,
    OP_COMPARE = 4'd8,
    OP_READ    = 4'd9
  } cam_op_e;

  // control register field positions
  localparam int CTL_RST     = 15;
  localparam int CTL_MF_HI   = 14;
  localparam int CTL_MF_LO   = 13;
  localparam int CTL_FF_HI   = 12;
  localparam int CTL_FF_LO   = 11;
  localparam int CTL_MSK_HI  = 5;
  localparam int CTL_MSK_LO  = 4;
  localparam int CTL_STEP_HI = 3;
  localparam int CTL_STEP_LO = 2;

  localparam logic [1:0] FLAG_OFF  = 2'b01;
  localparam logic [1:0] SEL_MSK1  = 2'b01;
  localparam logic [1:0] SEL_MSK2  = 2'b10;
  localparam logic [1:0] STEP_INC  = 2'b01;
  localparam logic [1:0] STEP_DEC  = 2'b10;

endpackage

// File: rtl/cam_prienc.sv
module cam_prienc #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic          multi,
  output logic [IW-1:0] idx
);

  assign any   = |req;
  assign multi = |(req & (req - 1'b1));

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/cam_regs.sv
module cam_regs
  import cam_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int BUS   = 16,
  parameter int AW    = 4,
  parameter int SEGS  = WIDTH / BUS,
  parameter int SW    = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic             clk,
  input  logic             clr,
  input  cam_op_e          op,
  input  logic [SW-1:0]    seg,
  input  logic [BUS-1:0]   din,
  output logic [15:0]      ctrl,
  output logic [WIDTH-1:0] cmp,
  output logic [WIDTH-1:0] msk1,
  output logic [WIDTH-1:0] msk2,
  output logic [AW-1:0]    ar
);

  localparam logic [SW-1:0] LAST_SEG = SW'(SEGS - 1);

  logic [1:0] step_mode;
  assign step_mode = ctrl[CTL_STEP_HI:CTL_STEP_LO];

  always_ff @(posedge clk) begin
    if (clr) begin
      ctrl <= '0;
      cmp  <= '0;
      msk1 <= '0;
      msk2 <= '0;
      ar   <= '0;
    end else begin
      case (op)
        OP_CTRL: ctrl <= {1'b0, din[14:0]};
        OP_CMP:  cmp[seg*BUS +: BUS]  <= din;
        OP_MSK1: msk1[seg*BUS +: BUS] <= din;
        OP_MSK2: msk2[seg*BUS +: BUS] <= din;
        OP_ADDR: ar <= din[AW-1:0];
        OP_DATA: begin
          if (seg == LAST_SEG) begin
            if (step_mode == STEP_INC)      ar <= ar + 1'b1;
            else if (step_mode == STEP_DEC) ar <= ar - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cam_array.sv
module cam_array #(
  parameter int N     = 16,
  parameter int WIDTH = 64,
  parameter int BUS   = 16,
  parameter int AW    = 4,
  parameter int SEGS  = WIDTH / BUS,
  parameter int SW    = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [SW-1:0]    wr_seg,
  input  logic [BUS-1:0]   wr_data,
  input  logic [BUS-1:0]   wr_keep,
  input  logic             vset_en,
  input  logic [AW-1:0]    vset_addr,
  input  logic             vset_val,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] dont_care,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_word,
  output logic [N-1:0]     hits,
  output logic [N-1:0]     valid
);

  logic [WIDTH-1:0] mem [N];
  logic [BUS-1:0]   old_seg;

  assign old_seg = mem[wr_addr][wr_seg*BUS +: BUS];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_addr][wr_seg*BUS +: BUS] <= (old_seg & wr_keep) | (wr_data & ~wr_keep);
  end

  always_ff @(posedge clk) begin
    if (clr)          valid <= '0;
    else if (vset_en) valid[vset_addr] <= vset_val;
  end

  assign rd_word = mem[rd_addr];

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hits[i] = valid[i] && (((mem[i] ^ key) & ~dont_care) == '0);
  end

endmodule

// File: rtl/masked_cam.sv
module masked_cam
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  parameter int BUS     = 16,
  parameter int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  parameter int SEGS    = WIDTH / BUS,
  parameter int SW      = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     op,
  input  logic [SW-1:0]  seg,
  input  logic [BUS-1:0] din,
  input  logic           mi_n,
  input  logic           fi_n,
  output logic           ma_n,
  output logic           mm_n,
  output logic           mf_n,
  output logic           ff_n,
  output logic [AW-1:0]  match_addr,
  output logic [AW-1:0]  next_free,
  output logic [BUS-1:0] rd_data,
  output logic [15:0]    ctrl_out
);

  cam_op_e          opc;
  logic             clr;
  logic [15:0]      ctrl;
  logic [WIDTH-1:0] cmp, msk1, msk2, act_mask;
  logic [AW-1:0]    ar;
  logic [ENTRIES-1:0] hits, valid;
  logic [WIDTH-1:0] rd_word;
  logic             hit_any, hit_multi, free_any, free_multi;
  logic [AW-1:0]    hit_idx, free_idx;
  logic             match_en, full_en;
  logic             vset_en;
  logic [AW-1:0]    vset_addr;
  logic             ma_q, mm_q;
  logic [AW-1:0]    hpm_q;
  logic [BUS-1:0]   rd_q;

  assign opc      = cam_op_e'(op);
  assign clr      = rst || (opc == OP_CTRL && din[CTL_RST]);
  assign match_en = ctrl[CTL_MF_HI:CTL_MF_LO] != FLAG_OFF;
  assign full_en  = ctrl[CTL_FF_HI:CTL_FF_LO] != FLAG_OFF;

  always_comb begin
    case (ctrl[CTL_MSK_HI:CTL_MSK_LO])
      SEL_MSK1: act_mask = msk1;
      SEL_MSK2: act_mask = msk2;
      default:  act_mask = '0;
    endcase
  end

  cam_regs #(.WIDTH(WIDTH), .BUS(BUS), .AW(AW), .SEGS(SEGS), .SW(SW)) u_regs (
    .clk (clk), .clr (clr), .op (opc), .seg (seg), .din (din),
    .ctrl(ctrl), .cmp (cmp), .msk1(msk1), .msk2(msk2), .ar (ar)
  );

  // validity update: by address register or by last winning match
  always_comb begin
    vset_addr = ar;
    vset_en   = 1'b0;
    if (opc == OP_VALID && !clr) begin
      if (din[1]) begin
        vset_addr = hpm_q;
        vset_en   = !ma_q && match_en && mi_n;
      end else begin
        vset_en   = 1'b1;
      end
    end
  end

  cam_array #(.N(ENTRIES), .WIDTH(WIDTH), .BUS(BUS), .AW(AW), .SEGS(SEGS), .SW(SW)) u_array (
    .clk      (clk),
    .clr      (clr),
    .wr_en    (opc == OP_DATA),
    .wr_addr  (ar),
    .wr_seg   (seg),
    .wr_data  (din),
    .wr_keep  (act_mask[seg*BUS +: BUS]),
    .vset_en  (vset_en),
    .vset_addr(vset_addr),
    .vset_val (din[0]),
    .key      (cmp),
    .dont_care(act_mask),
    .rd_addr  (ar),
    .rd_word  (rd_word),
    .hits     (hits),
    .valid    (valid)
  );

  cam_prienc #(.N(ENTRIES), .IW(AW)) u_hit_pe (
    .req(hits), .any(hit_any), .multi(hit_multi), .idx(hit_idx)
  );

  cam_prienc #(.N(ENTRIES), .IW(AW)) u_free_pe (
    .req(~valid), .any(free_any), .multi(free_multi), .idx(free_idx)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      ma_q  <= 1'b1;
      mm_q  <= 1'b1;
      hpm_q <= '0;
      rd_q  <= '0;
    end else begin
      if (opc == OP_COMPARE) begin
        ma_q  <= !hit_any;
        mm_q  <= !hit_multi;
        hpm_q <= hit_any ? hit_idx : '0;
      end
      if (opc == OP_READ) rd_q <= rd_word[seg*BUS +: BUS];
    end
  end

  assign ma_n       = ma_q;
  assign mm_n       = mm_q;
  assign match_addr = hpm_q;
  assign rd_data    = rd_q;
  assign ctrl_out   = ctrl;
  assign mf_n       = match_en ? (mi_n && ma_q) : mi_n;
  assign next_free  = free_any ? free_idx : '0;
  assign ff_n       = full_en ? !(!free_any && !fi_n && !free_multi) : fi_n;

endmodule

// File: rtl/masked_cam_chk.sv
module masked_cam_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          mi_n,
  input logic          fi_n,
  input logic          ma_n,
  input logic          mm_n,
  input logic          mf_n,
  input logic          ff_n,
  input logic [AW-1:0] match_addr,
  input logic [15:0]   ctrl_out
);

  logic after_rst;
  always_ff @(posedge clk) after_rst <= rst;

  // R2: one clock after reset the match flags are idle
  always_ff @(posedge clk) begin
    if (after_rst === 1'b1 && !rst)
      p_reset_idle_r2: assert (ma_n && mm_n && match_addr == '0);
  end

  p_ctrl_msb_zero_r1: assert property (@(posedge clk) disable iff (rst)
    ctrl_out[15] == 1'b0);

  p_multi_needs_match_r3: assert property (@(posedge clk) disable iff (rst)
    !mm_n |-> !ma_n);

  p_no_match_addr_zero_r4: assert property (@(posedge clk) disable iff (rst)
    ma_n |-> match_addr == '0);

  p_chain_upstream_r10: assert property (@(posedge clk) disable iff (rst)
    !mi_n |-> !mf_n);

  p_full_needs_fi_r11: assert property (@(posedge clk) disable iff (rst)
    !ff_n |-> !fi_n);

endmodule

bind masked_cam masked_cam_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mi_n(mi_n), .fi_n(fi_n), .ma_n(ma_n), .mm_n(mm_n),
  .mf_n(mf_n), .ff_n(ff_n), .match_addr(match_addr), .ctrl_out(ctrl_out)
);

// File: tb/masked_cam_test.sv
module masked_cam_test;

  localparam int ENTRIES = 8;
  localparam int WIDTH   = 64;
  localparam int BUS     = 16;
  localparam int AW      = 3;
  localparam int SW      = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [3:0]     op  = 4'd0;
  logic [SW-1:0]  seg = '0;
  logic [BUS-1:0] din = '0;
  logic           mi_n = 1'b1;
  logic           fi_n = 1'b1;
  logic           ma_n, mm_n, mf_n, ff_n;
  logic [AW-1:0]  match_addr, next_free;
  logic [BUS-1:0] rd_data;
  logic [15:0]    ctrl_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  masked_cam #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .BUS(BUS)) uut (
    .clk(clk), .rst(rst), .op(op), .seg(seg), .din(din), .mi_n(mi_n), .fi_n(fi_n),
    .ma_n(ma_n), .mm_n(mm_n), .mf_n(mf_n), .ff_n(ff_n), .match_addr(match_addr),
    .next_free(next_free), .rd_data(rd_data), .ctrl_out(ctrl_out)
  );

  function automatic logic [63:0] word(input int k);
    return {16'h1000 + 16'(k), 16'h2222, 16'h3333, 16'h4400 + 16'(k)};
  endfunction

  // {comparand, mask select, ma_n, mm_n, match_addr}
  localparam int NV = 6;
  localparam logic [71:0] VEC [NV] = '{
    {64'h1003_2222_3333_4403, 2'b00, 1'b0, 1'b1, 4'd3},
    {64'h1002_2222_3333_4402, 2'b00, 1'b0, 1'b0, 4'd2},
    {64'h1007_2222_3333_4407, 2'b00, 1'b1, 1'b1, 4'd0},
    {64'h1000_2222_3333_4400, 2'b01, 1'b0, 1'b0, 4'd0},
    {64'h1004_0000_0000_0000, 2'b10, 1'b0, 1'b1, 4'd4},
    {64'h1001_2222_3333_4401, 2'b11, 1'b0, 1'b1, 4'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input int s, input logic [15:0] d);
    @(negedge clk);
    op  = o;
    seg = SW'(s);
    din = d;
    @(negedge clk);
    op  = 4'd0;
  endtask

  task automatic load_cmp(input logic [63:0] w);
    for (int s = 0; s < 4; s++) issue(4'd2, s, w[s*16 +: 16]);
  endtask

  task automatic write_entry(input int a, input logic [63:0] w);
    issue(4'd5, 0, 16'(a));
    for (int s = 0; s < 4; s++) issue(4'd6, s, w[s*16 +: 16]);
  endtask

  task automatic search(input logic [63:0] w);
    load_cmp(w);
    issue(4'd8, 0, 16'h0);
  endtask

  task automatic set_valid(input int a, input logic v);
    issue(4'd5, 0, 16'(a));
    issue(4'd7, 0, {15'h0, v});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk("R2 ma_n", 32'(ma_n), 1);
    chk("R2 mm_n", 32'(mm_n), 1);
    chk("R2 match_addr", 32'(match_addr), 0);
    chk("R2 ctrl", 32'(ctrl_out), 0);
    chk("R2 rd_data", 32'(rd_data), 0);
    chk("R11 next_free empty", 32'(next_free), 0);
    chk("R11 ff_n empty", 32'(ff_n), 1);

    // R1 readback
    issue(4'd1, 0, 16'h0015);
    chk("R1 ctrl readback", 32'(ctrl_out), 32'h0015);
    issue(4'd1, 0, 16'h0000);

    write_entry(0, word(0));
    write_entry(1, word(1));
    write_entry(2, word(2));
    write_entry(3, word(3));
    write_entry(4, word(4));
    write_entry(5, word(2));
    write_entry(6, 64'h0);
    write_entry(7, 64'h7777_7777_7777_7777);
    for (int k = 0; k < 6; k++) set_valid(k, 1'b1);
    chk("R11 next_free", 32'(next_free), 6);
    chk("R11 ff_n not full", 32'(ff_n), 1);

    // masks: mask1 hides low nibble of segments 0 and 3; mask2 hides segments 0..2
    issue(4'd3, 0, 16'h000F); issue(4'd3, 1, 16'h0); issue(4'd3, 2, 16'h0); issue(4'd3, 3, 16'h000F);
    issue(4'd4, 0, 16'hFFFF); issue(4'd4, 1, 16'hFFFF); issue(4'd4, 2, 16'hFFFF); issue(4'd4, 3, 16'h0);

    // R3 R4 R5 vectors
    for (int v = 0; v < NV; v++) begin
      issue(4'd1, 0, {10'h0, VEC[v][7:6], 4'h0});
      search(VEC[v][71:8]);
      chk("R3 ma_n vector", 32'(ma_n), 32'(VEC[v][5]));
      chk("R3 mm_n vector", 32'(mm_n), 32'(VEC[v][4]));
      chk("R4 match_addr vector", 32'(match_addr), 32'(VEC[v][2:0]));
      chk("R5 ctrl select", 32'(ctrl_out[5:4]), 32'(VEC[v][7:6]));
    end

    // R6 masked write and R12 read
    issue(4'd1, 0, 16'h0010);
    issue(4'd5, 0, 16'd6);
    issue(4'd6, 0, 16'hFFFF);
    issue(4'd6, 1, 16'hFFFF);
    issue(4'd9, 0, 16'h0);
    chk("R6 protected bits kept", 32'(rd_data), 32'hFFF0);
    issue(4'd9, 1, 16'h0);
    chk("R12 read segment 1", 32'(rd_data), 32'hFFFF);

    // R7 increment then decrement
    issue(4'd1, 0, 16'h0004);
    write_entry(6, {4{16'h0606}});
    issue(4'd9, 0, 16'h0);
    chk("R7 increment", 32'(rd_data), 32'h7777);
    issue(4'd1, 0, 16'h0008);
    for (int s = 0; s < 4; s++) issue(4'd6, s, 16'h0707);
    issue(4'd9, 2, 16'h0);
    chk("R7 decrement", 32'(rd_data), 32'h0606);
    issue(4'd1, 0, 16'h0000);

    // R8 invalid entry excluded
    set_valid(2, 1'b0);
    search(word(2));
    chk("R8 ma_n", 32'(ma_n), 0);
    chk("R8 mm_n single", 32'(mm_n), 1);
    chk("R8 winner", 32'(match_addr), 5);
    chk("R11 next_free hole", 32'(next_free), 2);

    // R9 clear via last match
    search(word(3));
    issue(4'd7, 0, 16'h0002);
    search(word(3));
    chk("R9 winner cleared", 32'(ma_n), 1);
    search(word(4));
    issue(4'd1, 0, 16'h2000);
    issue(4'd7, 0, 16'h0002);
    issue(4'd1, 0, 16'h0000);
    search(word(4));
    chk("R9 ignored when flag off", 32'(ma_n), 0);
    mi_n = 1'b0;
    issue(4'd7, 0, 16'h0002);
    mi_n = 1'b1;
    search(word(4));
    chk("R9 ignored when upstream", 32'(match_addr), 4);

    // R10 chain
    #1 chk("R10 local match", 32'(mf_n), 0);
    search(word(7));
    #1 chk("R10 pass high", 32'(mf_n), 1);
    mi_n = 1'b0;
    #1 chk("R10 pass low", 32'(mf_n), 0);
    mi_n = 1'b1;
    issue(4'd1, 0, 16'h2000);
    search(word(4));
    #1 chk("R10 disabled follows mi_n", 32'(mf_n), 1);
    issue(4'd1, 0, 16'h0000);

    // R11 full
    set_valid(2, 1'b1); set_valid(3, 1'b1); set_valid(6, 1'b1); set_valid(7, 1'b1);
    chk("R11 next_free full", 32'(next_free), 0);
    #1 chk("R11 ff_n full fi high", 32'(ff_n), 1);
    fi_n = 1'b0;
    #1 chk("R11 ff_n full fi low", 32'(ff_n), 0);

    // R1 soft reset
    issue(4'd1, 0, 16'h8000);
    chk("R1 soft reset ctrl", 32'(ctrl_out), 0);
    chk("R1 soft reset ma_n", 32'(ma_n), 1);
    #1 chk("R1 soft reset ff_n", 32'(ff_n), 1);
    issue(4'd1, 0, 16'h0800);
    #1 chk("R11 full flag off", 32'(ff_n), 0);
    fi_n = 1'b1;

    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule